// File: doc/BRIEF.md
# Interrupt Context Snapshot Register

This block sits beside the interrupt arbiter of a two-channel UART. A fixed-priority arbiter runs all the time over the pending requests of both channels. Each channel has three FIFO request lines: receive with errors, receive, and transmit. There are also seven other sources: modem-line change, address match, flow-control status, receive timeout, break change, counter/timer and loopback error. The block does not expose the arbiter's live result. It freezes the current winner into an 8-bit context word. This happens only when the host starts an interrupt-acknowledge cycle or issues an explicit update command.

The context word has three fields. Bits 7:6 give the kind of interrupt. Bit 0 gives the channel, or the counter/timer number. Bits 5:1 hold one of two things, chosen by the kind: a quantised FIFO byte count for FIFO interrupts, or a source code for the other interrupts. The host reads the word directly. Its low bits also leave the block as part of the address of the global count, character, type and FIFO-data registers. Those registers therefore keep pointing at the captured context until the next capture.

Requests and FIFO fill levels are plain inputs. Interrupt-enable masking and the bus interface are handled outside the block. All pins are plain control and status pins, so no valid/ready handshake applies.

Top module: `icsr_snapshot`

## Requirements
- R1: A synchronous active-high `rst` clears the context word to 0x00 at the next rising clock edge.
- R2: The word loads only at a rising edge where `iack_start` or `upd_cmd` is high. At every other edge it keeps its value, whatever the requests and levels do.
- R3: Bits 7:6 encode the kind of interrupt: 2'b11 = receive with errors, 2'b10 = receive without errors, 2'b01 = transmit, 2'b00 = other source.
- R4: Bit 0 is 0 for channel A (or counter/timer 0) and 1 for channel B (or counter/timer 1).
- R5: When bits 7:6 are 2'b00, bits 5:1 hold the source code: 1 modem-line change, 2 address match, 3 flow-control status, 4 receive timeout, 5 break change, 6 counter/timer, 7 loopback error. `misc_req[s][c]` is the request of source code s+1 on channel c.
- R6: For FIFO kinds, bits 5:1 hold a count code taken from the winning channel's 9-bit level. The receive kinds use `rx_level` and the transmit kind uses `tx_level`. Levels 0 to 15 give code 0. Levels 16 to 23 give code 1. Levels 24 to 255 give floor(level/8)-1. Level 256 or more gives code 31.
- R7: Priority, highest first, is: receive with errors, receive, transmit, then the other sources in rising code order. Within each class, channel A wins over channel B.
- R8: A capture with no request pending loads 0x00.
- R9: When `iack_start` and `upd_cmd` are high in the same cycle, the block makes exactly one capture, identical to the capture either strobe makes alone.
- R10: `ctx_word` always shows the held word. `ctx_addr` always equals its low ADDR_W bits. Reading the word has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iack_start | input | 1 | Start of an interrupt-acknowledge cycle; triggers a capture |
| upd_cmd | input | 1 | Update command; triggers a capture |
| rx_err_req | input | 2 | Receive-with-errors request, one bit per channel |
| rx_req | input | 2 | Receive request, one bit per channel |
| tx_req | input | 2 | Transmit request, one bit per channel |
| misc_req | input | 7x2 | Other-source requests, indexed [code-1][channel] |
| rx_level | input | 2x9 | Receive FIFO fill level per channel |
| tx_level | input | 2x9 | Transmit FIFO level per channel |
| ctx_word | output | 8 | Held context word (host read) |
| ctx_addr | output | 6 | Low bits of the held word, used in global register addressing |

## Verification
A capture strobe and a change in the arbiter's winner can fall in the same cycle. Acknowledge and update can also arrive together. The bench changes requests and levels in every cycle, whether or not a strobe is present. It then judges two things. After a strobe, the word must match the winner computed from the inputs present at that edge. Without a strobe, the word must stay exactly as it was. Directed cycles assert both strobes at once and require the same single capture that either strobe alone would give.

// File: rtl/icsr_pkg.sv
package icsr_pkg;
  localparam int NCH   = 2;
  localparam int NSRC  = 7;
  localparam int CODEW = 5;

  typedef enum logic [1:0] {
    K_OTHER  = 2'b00,
    K_TX     = 2'b01,
    K_RX     = 2'b10,
    K_RX_ERR = 2'b11
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [CODEW-1:0]  code;
    logic              ch;
  } ctx_t;
endpackage

// File: rtl/icsr_count_enc.sv
module icsr_count_enc #(
  parameter int LVL_W = 9
) (
  input  logic [LVL_W-1:0]           level,
  output logic [icsr_pkg::CODEW-1:0] code
);
  localparam int FULL = 256;

  always_comb begin
    if (level >= LVL_W'(FULL))
      code = 5'd31;
    else if (level < LVL_W'(16))
      code = 5'd0;
    else if (level < LVL_W'(24))
      code = 5'd1;
    else
      code = level[7:3] - 5'd1;
  end
endmodule

// File: rtl/icsr_arbiter.sv
module icsr_arbiter
  import icsr_pkg::*;
#(
  parameter int LVL_W = 9
) (
  input  logic [NCH-1:0]             rx_err_req,
  input  logic [NCH-1:0]             rx_req,
  input  logic [NCH-1:0]             tx_req,
  input  logic [NSRC-1:0][NCH-1:0]   misc_req,
  input  logic [NCH-1:0][LVL_W-1:0]  rx_level,
  input  logic [NCH-1:0][LVL_W-1:0]  tx_level,
  output ctx_t                       winner
);
  logic [NCH-1:0][CODEW-1:0] rx_code;
  logic [NCH-1:0][CODEW-1:0] tx_code;

  for (genvar c = 0; c < NCH; c++) begin : g_enc
    icsr_count_enc #(.LVL_W(LVL_W)) rx_enc_i (.level(rx_level[c]), .code(rx_code[c]));
    icsr_count_enc #(.LVL_W(LVL_W)) tx_enc_i (.level(tx_level[c]), .code(tx_code[c]));
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    winner = '0;
    for (int c = 0; c < NCH; c++) begin
      if (!found && rx_err_req[c]) begin
        winner = '{kind: K_RX_ERR, code: rx_code[c], ch: c[0]};
        found  = 1'b1;
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (!found && rx_req[c]) begin
        winner = '{kind: K_RX, code: rx_code[c], ch: c[0]};
        found  = 1'b1;
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (!found && tx_req[c]) begin
        winner = '{kind: K_TX, code: tx_code[c], ch: c[0]};
        found  = 1'b1;
      end
    end
    for (int s = 0; s < NSRC; s++) begin
      for (int c = 0; c < NCH; c++) begin
        if (!found && misc_req[s][c]) begin
          winner = '{kind: K_OTHER, code: CODEW'(s + 1), ch: c[0]};
          found  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/icsr_snapshot.sv
module icsr_snapshot
  import icsr_pkg::*;
#(
  parameter int LVL_W  = 9,
  parameter int ADDR_W = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            iack_start,
  input  logic                            upd_cmd,
  input  logic [icsr_pkg::NCH-1:0]        rx_err_req,
  input  logic [icsr_pkg::NCH-1:0]        rx_req,
  input  logic [icsr_pkg::NCH-1:0]        tx_req,
  input  logic [icsr_pkg::NSRC-1:0][icsr_pkg::NCH-1:0] misc_req,
  input  logic [icsr_pkg::NCH-1:0][LVL_W-1:0] rx_level,
  input  logic [icsr_pkg::NCH-1:0][LVL_W-1:0] tx_level,
  output logic [7:0]                      ctx_word,
  output logic [ADDR_W-1:0]               ctx_addr
);
  ctx_t winner;
  ctx_t snap_q;
  logic capture;

  icsr_arbiter #(.LVL_W(LVL_W)) arb_i (
    .rx_err_req (rx_err_req),
    .rx_req     (rx_req),
    .tx_req     (tx_req),
    .misc_req   (misc_req),
    .rx_level   (rx_level),
    .tx_level   (tx_level),
    .winner     (winner)
  );

  assign capture = iack_start | upd_cmd;

  always_ff @(posedge clk) begin
    if (rst)
      snap_q <= '0;
    else if (capture)
      snap_q <= winner;
  end

  assign ctx_word = snap_q;
  assign ctx_addr = ctx_word[ADDR_W-1:0];
endmodule

// File: rtl/icsr_snapshot_chk.sv
module icsr_snapshot_chk #(
  parameter int LVL_W = 9
) (
  input logic       clk,
  input logic       rst,
  input logic       iack_start,
  input logic       upd_cmd,
  input logic [1:0] rx_err_req,
  input logic [1:0] rx_req,
  input logic [1:0] tx_req,
  input logic [6:0][1:0] misc_req,
  input logic [7:0] ctx_word
);
  logic cap;
  logic idle;
  logic rst_seen_q = 1'b0;

  assign cap  = iack_start | upd_cmd;
  assign idle = ~(|rx_err_req | |rx_req | |tx_req | |misc_req);

  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst_seen_q)
      AST_RESET_CLEAR: assert (ctx_word == 8'h00); // R1
  end

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(ctx_word)); // R2

  AST_OTHER_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ctx_word[7:6] == 2'b00) |-> (ctx_word[5:1] <= 5'd7)); // R5

  AST_RXERR_WINS: assert property (@(posedge clk) disable iff (rst)
    (cap && |rx_err_req) |=> (ctx_word[7:6] == 2'b11)); // R7

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cap && idle) |=> (ctx_word == 8'h00)); // R8
endmodule

bind icsr_snapshot icsr_snapshot_chk #(.LVL_W(LVL_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .iack_start (iack_start),
  .upd_cmd    (upd_cmd),
  .rx_err_req (rx_err_req),
  .rx_req     (rx_req),
  .tx_req     (tx_req),
  .misc_req   (misc_req),
  .ctx_word   (ctx_word)
);

// File: tb/icsr_snapshot_tb.sv
module icsr_snapshot_tb_top;
  logic clk = 1'b0;
  logic rst, iack_start, upd_cmd;
  logic [1:0] rx_err_req, rx_req, tx_req;
  logic [6:0][1:0] misc_req;
  logic [1:0][8:0] rx_level, tx_level;
  logic [7:0] ctx_word;
  logic [5:0] ctx_addr;
  int total = 0, bad = 0, cycles = 0;
  logic [7:0] held;

  always #4 clk = ~clk;

  icsr_snapshot dut_i (
    .clk(clk), .rst(rst), .iack_start(iack_start), .upd_cmd(upd_cmd),
    .rx_err_req(rx_err_req), .rx_req(rx_req), .tx_req(tx_req),
    .misc_req(misc_req), .rx_level(rx_level), .tx_level(tx_level),
    .ctx_word(ctx_word), .ctx_addr(ctx_addr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [4:0] cc(input logic [8:0] lv);
    if (lv >= 9'd256) return 5'd31;
    if (lv < 9'd16) return 5'd0;
    if (lv < 9'd24) return 5'd1;
    return 5'((lv / 8) - 1);
  endfunction

  function automatic logic [7:0] model();
    for (int c = 0; c < 2; c++) if (rx_err_req[c]) return {2'b11, cc(rx_level[c]), c[0]};
    for (int c = 0; c < 2; c++) if (rx_req[c])     return {2'b10, cc(rx_level[c]), c[0]};
    for (int c = 0; c < 2; c++) if (tx_req[c])     return {2'b01, cc(tx_level[c]), c[0]};
    for (int s = 0; s < 7; s++)
      for (int c = 0; c < 2; c++) if (misc_req[s][c]) return {2'b00, 5'(s + 1), c[0]};
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic clear_in();
    iack_start = 0; upd_cmd = 0; rx_err_req = 0; rx_req = 0; tx_req = 0;
    misc_req = '0; rx_level = '0; tx_level = '0;
  endtask

  // drive at negedge, capture at posedge, check at following negedge
  task automatic step(input logic ia, input logic up, input string req);
    logic [7:0] e;
    iack_start = ia; upd_cmd = up;
    e = (ia | up) ? model() : held;
    @(negedge clk);
    check(req, ctx_word, e);
    check("R10 addr", {2'b00, ctx_addr}, {2'b00, e[5:0]});
    held = e;
    iack_start = 0; upd_cmd = 0;
  endtask

  task automatic lvl_case(input logic [8:0] lv, input logic [4:0] code);
    clear_in(); rx_req = 2'b10; rx_level[1] = lv;
    step(1, 0, "R6 level");
    check("R6 code", ctx_word, {2'b10, code, 1'b1});
  endtask

  initial begin
    void'($urandom(32'd1234));
    clear_in(); rst = 1; held = 8'h00;
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R1 reset", ctx_word, 8'h00);

    // R6 boundaries
    lvl_case(9'd0, 5'd0);   lvl_case(9'd1, 5'd0);   lvl_case(9'd15, 5'd0);
    lvl_case(9'd16, 5'd1);  lvl_case(9'd23, 5'd1);  lvl_case(9'd24, 5'd2);
    lvl_case(9'd255, 5'd30); lvl_case(9'd256, 5'd31);

    // R3 R4 transmit on channel A, level 40 -> code 4
    clear_in(); tx_req = 2'b01; tx_level[0] = 9'd40;
    step(0, 1, "R3 R4 tx");
    check("R3 tx word", ctx_word, 8'b01_00100_0);

    // R5 counter/timer 1 (code 6, ch 1)
    clear_in(); misc_req[5] = 2'b10;
    step(1, 0, "R5 ct");
    check("R5 word", ctx_word, 8'b00_00110_1);

    // R7 rx beats tx, rx_err on B beats rx on A
    clear_in(); rx_req = 2'b01; tx_req = 2'b11; rx_err_req = 2'b10; rx_level[1] = 9'd100;
    step(1, 0, "R7 prio");
    check("R7 word", ctx_word, 8'b11_01011_1);

    // R2 hold while winner changes
    clear_in(); misc_req[0] = 2'b01;
    step(0, 0, "R2 hold");
    check("R2 held", ctx_word, 8'b11_01011_1);

    // R9 both strobes
    step(1, 1, "R9 both");
    check("R9 word", ctx_word, 8'b00_00001_0);

    // R8 empty capture
    clear_in();
    step(0, 1, "R8 empty");
    check("R8 word", ctx_word, 8'h00);

    // random mix with strobes and winner changes every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] sel;
      rx_err_req = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
      rx_req     = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      tx_req     = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
      for (int s = 0; s < 7; s++) misc_req[s] = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
      for (int c = 0; c < 2; c++) begin
        rx_level[c] = 9'($urandom % 257);
        tx_level[c] = 9'($urandom % 257);
      end
      sel = 2'($urandom);
      step(sel[0], sel[1], "R2 R3 R6 R7 random");
    end

    // R1 reset mid-run
    clear_in(); rx_req = 2'b01; step(1, 0, "R7 pre-reset");
    rst = 1; @(negedge clk); rst = 0; held = 8'h00;
    check("R1 reset2", ctx_word, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule